// File: doc/BRIEF.md
# Page Access Permission Guard

This block decides whether a single, already translated memory access may proceed under the 3-bit access code of its page table entry. It receives the kind of access (data read, data write, instruction fetch, or write combined with fetch) and the privilege level. It reports a fault type for the access. When the access is allowed, it reports the read, write and execute rights that may be cached for the page.

Every faulting access is recorded in a status register and in a fault address register. A second fault that arrives before software has read the status register is flagged as an overflow. The block also chooses between an instruction-access trap and a data-access trap. A no-fault mode lets user accesses proceed despite a permission fault, and it suppresses every trap. Table walking and memory traffic happen outside the block.

Top module: `pte_perm_guard`

## Requirements
- R1: The access class is the 3-bit value {write, fetch, supervisor}, with write in bit 2. It is recorded in bits 7:5 of the status register when a fault is logged.
- R2: A user access (supervisor low) to a page whose access code is 6 or 7 yields fault type 3, which means a privilege violation.
- R3: In every other case, fault type 2 (protection) is reported if the rights table for the access's privilege lacks a needed right. A plain read needs read. A write needs write. A fetch needs execute, and write with fetch needs both. Otherwise the fault type is 0. With no valid request, the fault type is 0.
- R4: The supervisor rights {r,w,x} for codes 0..7 are R, RW, RX, RWX, X, RW, RX, RWX. The user rights are the same except that code 5 is R only and codes 6 and 7 grant nothing. The grant outputs show these rights when the access does not fault, and they are all zero when it faults.
- R5: The write grant is cleared unless the entry's modified bit (bit 6) is set. The access code comes from entry bits 4:2.
- R6: In no-fault mode, a faulting user access still receives its rights on the grant outputs. A faulting supervisor access does not.
- R7: A logged fault writes bit 1 (address valid), the fault type in bits 4:2 and the access class in bits 7:5 into the status register. The fault address register takes the virtual address with its low 12 bits cleared.
- R8: If the status register is nonzero when a fault is logged and no read happens in the same cycle, the old contents are discarded and bit 0 (overflow) is set under the new fields.
- R9: A status read shows the current value and clears the register at the next edge. If a fault is logged in the same cycle as a read, the register takes only the new fault's fields, with no overflow.
- R10: A fault raises a trap only when no-fault mode is off and traps are enabled. A fetch raises the instruction trap, and any other access raises the data trap. The two traps are never raised together.
- R11: After reset, both registers and both trap outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | Access writes |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is made in supervisor mode |
| req_vaddr | input | VA_W | Virtual address of the access |
| pte | input | PTE_W | Page table entry of the target page |
| nofault_mode | input | 1 | No-fault mode enable |
| traps_on | input | 1 | Traps are enabled |
| stat_rd | input | 1 | Read strobe for the status register (clears it) |
| grant_r | output | 1 | Read right granted |
| grant_w | output | 1 | Write right granted |
| grant_x | output | 1 | Execute right granted |
| fault_type | output | 3 | 0 none, 2 protection, 3 privilege |
| trap_insn | output | 1 | Instruction-access trap |
| trap_data | output | 1 | Data-access trap |
| stat_q | output | 8 | Fault status register |
| fault_addr_q | output | VA_W | Fault address register |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 32-bit entry, the access code at bit 2 and the modified bit at bit 6. With this setting, all 64 pairs of access class and access code can be swept against the fault matrix and the rights tables. Directed tasks then cover logging, overflow, a read that coincides with a fault, trap gating, and the no-fault override for each privilege level. They also check that the write grant depends on the modified bit.

// File: rtl/pte_perm_guard.sv
module pte_perm_guard #(
  parameter int VA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int PAGE_LSB = 12,
  parameter int ACC_LSB  = 2,
  parameter int MOD_BIT  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_fetch,
  input  logic             req_super,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PTE_W-1:0] pte,
  input  logic             nofault_mode,
  input  logic             traps_on,
  input  logic             stat_rd,
  output logic             grant_r,
  output logic             grant_w,
  output logic             grant_x,
  output logic [2:0]       fault_type,
  output logic             trap_insn,
  output logic             trap_data,
  output logic [7:0]       stat_q,
  output logic [VA_W-1:0]  fault_addr_q
);
  localparam logic [2:0] FT_NONE = 3'd0;
  localparam logic [2:0] FT_PROT = 3'd2;
  localparam logic [2:0] FT_PRIV = 3'd3;

  logic [2:0] acc, cls, need, sup_rights, usr_rights, rights, grants;
  logic       user, has_fault, suppress, trap;
  logic [7:0] stat_d;

  assign acc  = pte[ACC_LSB +: 3];
  assign cls  = {req_write, req_fetch, req_super};
  assign user = ~req_super;
  assign need = {~req_write & ~req_fetch, req_write, req_fetch};

  always_comb begin
    case (acc)
      3'd0:    sup_rights = 3'b100;
      3'd1:    sup_rights = 3'b110;
      3'd2:    sup_rights = 3'b101;
      3'd3:    sup_rights = 3'b111;
      3'd4:    sup_rights = 3'b001;
      3'd5:    sup_rights = 3'b110;
      3'd6:    sup_rights = 3'b101;
      default: sup_rights = 3'b111;
    endcase
  end

  assign usr_rights = (acc == 3'd5) ? 3'b100 :
                      (acc[2] & acc[1]) ? 3'b000 : sup_rights;
  assign rights = user ? usr_rights : sup_rights;

  always_comb begin
    if (!req_valid)                        fault_type = FT_NONE;
    else if (user && acc[2] && acc[1])     fault_type = FT_PRIV;
    else if ((need & ~rights) != 3'b000)   fault_type = FT_PROT;
    else                                   fault_type = FT_NONE;
  end

  assign has_fault = req_valid && (fault_type != FT_NONE);
  assign suppress  = nofault_mode & user;
  assign grants    = (req_valid && (!has_fault || suppress)) ?
                     (rights & {1'b1, pte[MOD_BIT], 1'b1}) : 3'b000;
  assign {grant_r, grant_w, grant_x} = grants;

  assign trap      = has_fault & ~nofault_mode & traps_on;
  assign trap_insn = trap & req_fetch;
  assign trap_data = trap & ~req_fetch;

  always_comb begin
    stat_d = stat_q;
    if (has_fault) begin
      stat_d = (!stat_rd && stat_q != 8'd0) ? 8'd1 : 8'd0;
      stat_d = stat_d | {cls, fault_type, 2'b10};
    end else if (stat_rd) begin
      stat_d = 8'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q       <= '0;
      fault_addr_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (has_fault)
        fault_addr_q <= {req_vaddr[VA_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
    end
  end

  // R10
  traps_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_insn, trap_data}));

  // R10
  nofault_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nofault_mode |-> !(trap_insn || trap_data));

  // R5
  write_needs_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_w |-> pte[MOD_BIT]);

  // R7
  log_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fault_type != 3'd0) |=> stat_q[1]);

  // R8
  overflow_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fault_type != 3'd0 && !stat_rd && stat_q != 8'd0) |=> stat_q[0]);

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(req_valid && fault_type != 3'd0)) |=> stat_q == 8'd0);

  // R2
  user_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_super && pte[ACC_LSB+2] && pte[ACC_LSB+1]) |-> fault_type == 3'd3);
endmodule

// File: tb/pte_perm_guard_tb_top.sv
module pte_perm_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_fetch = 0, req_super = 0;
  logic [31:0] req_vaddr = '0, pte = '0;
  logic nofault_mode = 0, traps_on = 0, stat_rd = 0;
  logic grant_r, grant_w, grant_x, trap_insn, trap_data;
  logic [2:0] fault_type;
  logic [7:0] stat_q;
  logic [31:0] fault_addr_q;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pte_perm_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_fetch(req_fetch), .req_super(req_super), .req_vaddr(req_vaddr),
    .pte(pte), .nofault_mode(nofault_mode), .traps_on(traps_on), .stat_rd(stat_rd),
    .grant_r(grant_r), .grant_w(grant_w), .grant_x(grant_x),
    .fault_type(fault_type), .trap_insn(trap_insn), .trap_data(trap_data),
    .stat_q(stat_q), .fault_addr_q(fault_addr_q));

  // fault matrix rows per class, 2 bits per code: 0 none, 2 protection, 3 privilege
  logic [15:0] fmat [8];
  initial begin
    fmat[0] = 16'hF200; fmat[1] = 16'h0200; fmat[2] = 16'hF80A; fmat[3] = 16'h080A;
    fmat[4] = 16'hFA22; fmat[5] = 16'h2222; fmat[6] = 16'hFA2A; fmat[7] = 16'h2A2A;
  end
  localparam logic [23:0] SUP_R = {3'b111,3'b101,3'b110,3'b001,3'b111,3'b101,3'b110,3'b100};
  localparam logic [23:0] USR_R = {3'b000,3'b000,3'b100,3'b001,3'b111,3'b101,3'b110,3'b100};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(bit w, bit f, bit s, logic [2:0] code, bit md, logic [31:0] va);
    req_valid = 1; req_write = w; req_fetch = f; req_super = s;
    pte = {25'd0, md, 1'b0, code, 2'b00}; req_vaddr = va;
  endtask

  task automatic idle();
    req_valid = 0; stat_rd = 0;
  endtask

  task automatic t_reset();
    chk("R11 stat", stat_q, 0);
    chk("R11 faddr", fault_addr_q, 0);
    chk("R11 traps", {trap_insn, trap_data}, 0);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 8; k++) begin
        logic [1:0] ft;
        logic [2:0] r;
        put(c[2], c[1], c[0], k[2:0], 1'b1, 32'h0);
        ft = fmat[c][2*k +: 2];
        r = c[0] ? SUP_R[3*k +: 3] : USR_R[3*k +: 3];
        #2;
        chk(ft == 3 ? "R2 type" : "R3 type", fault_type, {1'b0, ft});
        chk("R4 grants", {grant_r, grant_w, grant_x}, ft != 0 ? 3'b000 : r);
        @(negedge clk);
      end
    end
    idle(); stat_rd = 1; @(negedge clk); stat_rd = 0;
    chk("R9 cleared after sweep", stat_q, 0);
  endtask

  task automatic t_modified();
    put(0, 0, 1, 3'd1, 1'b0, 0); req_write = 1; #2;
    chk("R5 write dropped", {grant_r, grant_w, grant_x}, 3'b100);
    pte[6] = 1'b1; #1;
    chk("R5 write kept", {grant_r, grant_w, grant_x}, 3'b110);
    idle(); #1;
    chk("R3 idle type", fault_type, 0);
    @(negedge clk);
    chk("R3 idle no log", stat_q, 0);
  endtask

  task automatic t_log_overflow();
    traps_on = 1;
    put(1, 0, 0, 3'd0, 1'b1, 32'h1234_5678); #2;
    chk("R10 data trap", {trap_insn, trap_data}, 2'b01);
    @(negedge clk);
    chk("R1 R7 stat", stat_q, 8'h8A);
    chk("R7 faddr", fault_addr_q, 32'h1234_5000);
    put(0, 1, 0, 3'd6, 1'b1, 32'hABCD_EFFF); #2;
    chk("R10 insn trap", {trap_insn, trap_data}, 2'b10);
    @(negedge clk);
    chk("R8 overflow", stat_q, 8'h4F);
    chk("R7 faddr2", fault_addr_q, 32'hABCD_E000);
    idle(); stat_rd = 1; #2;
    chk("R9 read value", stat_q, 8'h4F);
    @(negedge clk); stat_rd = 0;
    chk("R9 cleared", stat_q, 0);
    traps_on = 0;
  endtask

  task automatic t_read_collide();
    put(0, 0, 1, 3'd4, 1'b1, 32'h0000_2000); @(negedge clk);
    chk("R7 first", stat_q, 8'h2A);
    put(0, 0, 1, 3'd4, 1'b1, 32'h0000_3000); stat_rd = 1; @(negedge clk);
    chk("R9 collide no overflow", stat_q, 8'h2A);
    chk("R9 collide addr", fault_addr_q, 32'h0000_3000);
    idle(); stat_rd = 1; @(negedge clk); idle();
  endtask

  task automatic t_gating();
    traps_on = 0;
    put(0, 1, 1, 3'd0, 1'b1, 0); #2;
    chk("R10 traps off", {trap_insn, trap_data}, 0);
    traps_on = 1; nofault_mode = 1;
    put(0, 0, 0, 3'd4, 1'b1, 0); #2;
    chk("R6 user override grants", {grant_r, grant_w, grant_x}, 3'b001);
    chk("R6 type still", fault_type, 2);
    chk("R10 nofault no trap", {trap_insn, trap_data}, 0);
    put(0, 0, 1, 3'd4, 1'b1, 0); #2;
    chk("R6 supervisor not overridden", {grant_r, grant_w, grant_x}, 3'b000);
    @(negedge clk);
    chk("R7 still logged", stat_q[1], 1);
    nofault_mode = 0; idle(); traps_on = 0;
    stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_sweep();
    t_modified();
    t_log_overflow();
    t_read_collide();
    t_gating();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule